// File: doc/BRIEF.md
# Dual-Load Banked L1 Data Cache Read Path

This block is the load side of a level-one data cache that accepts two independent 8-byte loads in every cycle. It holds 64 KiB as a 2-way set-associative array of 64-byte lines. Each line is cut into eight 8-byte slices, and slice k of every line lives in bank k. Each bank is a single-ported RAM, so two loads can both go ahead in one cycle when they need different banks. The tag store is kept twice, one copy per load port, which lets both ports compare tags at the same time without sharing a read port.

A load is presented with a valid bit and a byte address. Exactly two clock edges later the matching response port shows a valid response. The response carries either the 8-byte word with hit set, a plain miss, or a retry, which tells the requester to issue the same load again. Lines are installed through a fill port that carries the whole 64-byte line in one cycle. That cycle writes every bank and both tag copies, so neither load port can be served during it. The requester fills only lines that are not already resident. Stores, write-back and coherence belong to other blocks.

Top module: `dcache_dual_load`

## Requirements
- R1: While reset is held and on the first cycle after it, neither response port shows a valid response.
- R2: A load presented with its valid bit high in cycle T gives a response with valid high on the same port after the second rising edge. A port with no load in cycle T gives valid low at that point.
- R3: A load that hits returns hit=1, retry=0, and the 8-byte word whose slice number is address bits [5:3]. Slice k is bits [64k+63:64k] of the fill data. The set is address bits [14:6] and the tag is bits [31:15].
- R4: A load that misses returns hit=0, retry=0 and data zero. Any response with retry=1 also has hit=0 and data zero.
- R5: When both ports load in one cycle from different banks (different bits [5:3]), both are served with a hit or miss, and neither gets a retry.
- R6: When both ports load from the same bank but from different 8-byte words, port 0 is served and port 1 gets retry=1.
- R7: When both ports load the identical 8-byte word (equal bits [31:3]), both are served and both return the same hit flag and data.
- R8: In a cycle where a fill is presented, every load on either port gets retry=1.
- R9: A fill goes into way 0 if it is invalid in that set, otherwise into way 1 if that way is invalid, otherwise into the way that the set's replacement bit names. The filled line can be hit by a load in the next cycle. A fill marks the other way as next to replace.
- R10: A hit in way w marks the other way as next to replace in that set. When both ports hit the same set in one cycle, port 0's update is the one kept. A fill sees the hits of loads issued at least two cycles before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld0_valid | input | 1 | Load request on port 0 |
| ld0_addr | input | 32 | Byte address of port 0 load |
| ld1_valid | input | 1 | Load request on port 1 |
| ld1_addr | input | 32 | Byte address of port 1 load |
| fill_valid | input | 1 | Install a line this cycle |
| fill_addr | input | 32 | Address of the line being installed |
| fill_line | input | 512 | Whole line, slice k in bits [64k+63:64k] |
| rsp0_valid | output | 1 | Port 0 response present |
| rsp0_hit | output | 1 | Port 0 load hit |
| rsp0_retry | output | 1 | Port 0 load must be reissued |
| rsp0_data | output | 64 | Port 0 load data |
| rsp1_valid | output | 1 | Port 1 response present |
| rsp1_hit | output | 1 | Port 1 load hit |
| rsp1_retry | output | 1 | Port 1 load must be reissued |
| rsp1_data | output | 64 | Port 1 load data |

## Verification
Every load response is due after the second rising edge that follows the cycle in which the load was presented. The edges are the one that registers the bank and tag reads and the one that registers the response. The bench drives inputs on the falling edge and keeps a two-deep queue of expected responses. Each entry is computed from a bench model of tags, valid bits, replacement bits and line contents at issue time, and the bench compares it two falling edges later. A fill changes the model at once, because a load in the very next cycle must see the new line. Before every fill the bench leaves one idle cycle, so that the replacement bits written by earlier hits have landed by the time the fill reads them.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  localparam int NPORT = 2;

  typedef logic [NPORT-1:0] port_mask_t;

  // way chosen for an incoming line: first invalid way, else the replacement bit
  function automatic logic pick_victim(input logic [1:0] vld, input logic repl);
    if (!vld[0])      return 1'b0;
    else if (!vld[1]) return 1'b1;
    else              return repl;
  endfunction
endpackage

// File: rtl/dcache_tag_copy.sv
module dcache_tag_copy #(
  parameter int SETS  = 512,
  parameter int TAG_W = 17,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SET_W-1:0]   rd_set,
  input  logic               wr_en,
  input  logic [SET_W-1:0]   wr_set,
  input  logic               wr_way,
  input  logic [TAG_W-1:0]   wr_tag,
  output logic [2*TAG_W-1:0] rd_tags,
  output logic [1:0]         rd_vld,
  output logic [1:0]         wr_set_vld
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    localparam logic WB = 1'(w);
    logic [TAG_W-1:0] mem [SETS];
    logic [TAG_W-1:0] tag_q;
    logic [SETS-1:0]  vbits;
    logic             vld_q;

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == WB) mem[wr_set] <= wr_tag;
      tag_q <= mem[rd_set];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vbits <= '0;
        vld_q <= 1'b0;
      end else begin
        if (wr_en && wr_way == WB) vbits[wr_set] <= 1'b1;
        vld_q <= vbits[rd_set];
      end
    end

    assign rd_tags[w*TAG_W +: TAG_W] = tag_q;
    assign rd_vld[w]     = vld_q;
    assign wr_set_vld[w] = vbits[wr_set];
  end
endmodule

// File: rtl/dcache_bank.sv
module dcache_bank #(
  parameter int SETS   = 512,
  parameter int WORD_W = 64,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic                clk,
  input  logic                en,
  input  logic [SET_W-1:0]    set,
  input  logic                wr_en,
  input  logic                wr_way,
  input  logic [WORD_W-1:0]   wr_word,
  output logic [2*WORD_W-1:0] rd_words
);
  // one address port shared by both way halves: a single-ported bank
  for (genvar w = 0; w < 2; w++) begin : g_way
    localparam logic WB = 1'(w);
    logic [WORD_W-1:0] mem [SETS];
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (en) begin
        if (wr_en && wr_way == WB) mem[set] <= wr_word;
        q <= mem[set];
      end
    end
    assign rd_words[w*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/dcache_bank_arb.sv
module dcache_bank_arb #(
  parameter int ADDR_W = 32,
  parameter int NBANK  = 8,
  parameter int SETS   = 512,
  parameter int OFF_W  = 3,
  localparam int BANK_W = $clog2(NBANK),
  localparam int SET_W  = $clog2(SETS),
  localparam int SET_LO = OFF_W + BANK_W
) (
  input  logic                    ld0_v,
  input  logic [ADDR_W-1:0]       ld0_a,
  input  logic                    ld1_v,
  input  logic [ADDR_W-1:0]       ld1_a,
  input  logic                    fill_v,
  input  logic [SET_W-1:0]        fill_set,
  output dcache_pkg::port_mask_t  serve,
  output logic [NBANK-1:0]        bank_en,
  output logic [NBANK*SET_W-1:0]  bank_set
);
  logic [BANK_W-1:0] b0, b1;
  logic [SET_W-1:0]  s0, s1;
  logic              same_word, clash;

  assign b0 = ld0_a[OFF_W +: BANK_W];
  assign b1 = ld1_a[OFF_W +: BANK_W];
  assign s0 = ld0_a[SET_LO +: SET_W];
  assign s1 = ld1_a[SET_LO +: SET_W];
  assign same_word = (ld0_a[ADDR_W-1:OFF_W] == ld1_a[ADDR_W-1:OFF_W]);
  assign clash     = ld0_v && ld1_v && (b0 == b1) && !same_word;

  assign serve[0] = ld0_v && !fill_v;
  assign serve[1] = ld1_v && !fill_v && !clash;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [BANK_W-1:0] BID = BANK_W'(b);
    logic use0, use1;
    assign use0 = serve[0] && (b0 == BID);
    assign use1 = serve[1] && (b1 == BID);
    assign bank_en[b] = fill_v || use0 || use1;
    assign bank_set[b*SET_W +: SET_W] = fill_v ? fill_set : (use0 ? s0 : s1);
  end
endmodule

// File: rtl/dcache_dual_load.sv
module dcache_dual_load #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int SETS       = 512,
  localparam int WORD_W = WORD_BYTES * 8,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int NBANK  = LINE_BYTES / WORD_BYTES,
  localparam int OFF_W  = $clog2(WORD_BYTES),
  localparam int BANK_W = $clog2(NBANK),
  localparam int SET_W  = $clog2(SETS),
  localparam int SET_LO = OFF_W + BANK_W,
  localparam int TAG_LO = SET_LO + SET_W,
  localparam int TAG_W  = ADDR_W - TAG_LO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld0_valid,
  input  logic [ADDR_W-1:0] ld0_addr,
  input  logic              ld1_valid,
  input  logic [ADDR_W-1:0] ld1_addr,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [LINE_W-1:0] fill_line,
  output logic              rsp0_valid,
  output logic              rsp0_hit,
  output logic              rsp0_retry,
  output logic [WORD_W-1:0] rsp0_data,
  output logic              rsp1_valid,
  output logic              rsp1_hit,
  output logic              rsp1_retry,
  output logic [WORD_W-1:0] rsp1_data
);
  import dcache_pkg::*;

  logic [ADDR_W-1:0]       ld_addr [NPORT];
  logic                    ld_v    [NPORT];
  port_mask_t              serve;
  logic [NBANK-1:0]        bank_en;
  logic [NBANK*SET_W-1:0]  bank_set;
  logic [SET_W-1:0]        fill_set;
  logic [TAG_W-1:0]        fill_tag;
  logic [1:0]              set_vld [NPORT];
  logic                    victim;
  logic [SETS-1:0]         repl;
  logic [2*WORD_W-1:0]     bank_q  [NBANK];
  logic [2*TAG_W-1:0]      tags_q  [NPORT];
  logic [1:0]              vld_q   [NPORT];

  // stage 1: request state captured alongside the RAM reads
  logic                    s1_v     [NPORT];
  logic                    s1_serve [NPORT];
  logic [TAG_W-1:0]        s1_tag   [NPORT];
  logic [SET_W-1:0]        s1_set   [NPORT];
  logic [BANK_W-1:0]       s1_bank  [NPORT];

  // stage 2: lookup result and registered response
  logic                    hit      [NPORT];
  logic                    hit_way  [NPORT];
  logic [WORD_W-1:0]       word     [NPORT];
  logic                    r_valid  [NPORT];
  logic                    r_hit    [NPORT];
  logic                    r_retry  [NPORT];
  logic [WORD_W-1:0]       r_data   [NPORT];

  logic unused_bits;
  assign unused_bits = ^{ld0_addr[OFF_W-1:0], ld1_addr[OFF_W-1:0], fill_addr[SET_LO-1:0]};

  assign ld_addr[0] = ld0_addr;
  assign ld_addr[1] = ld1_addr;
  assign ld_v[0]    = ld0_valid;
  assign ld_v[1]    = ld1_valid;
  assign fill_set   = fill_addr[SET_LO +: SET_W];
  assign fill_tag   = fill_addr[TAG_LO +: TAG_W];
  assign victim     = pick_victim(set_vld[0] & set_vld[1], repl[fill_set]);

  dcache_bank_arb #(.ADDR_W(ADDR_W), .NBANK(NBANK), .SETS(SETS), .OFF_W(OFF_W)) u_arb (
    .ld0_v(ld0_valid), .ld0_a(ld0_addr), .ld1_v(ld1_valid), .ld1_a(ld1_addr),
    .fill_v(fill_valid), .fill_set(fill_set),
    .serve(serve), .bank_en(bank_en), .bank_set(bank_set)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dcache_bank #(.SETS(SETS), .WORD_W(WORD_W)) u_bank (
      .clk(clk), .en(bank_en[b]), .set(bank_set[b*SET_W +: SET_W]),
      .wr_en(fill_valid), .wr_way(victim), .wr_word(fill_line[b*WORD_W +: WORD_W]),
      .rd_words(bank_q[b])
    );
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dcache_tag_copy #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst(rst), .rd_set(ld_addr[p][SET_LO +: SET_W]),
      .wr_en(fill_valid), .wr_set(fill_set), .wr_way(victim), .wr_tag(fill_tag),
      .rd_tags(tags_q[p]), .rd_vld(vld_q[p]), .wr_set_vld(set_vld[p])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        s1_v[p]     <= 1'b0;
        s1_serve[p] <= 1'b0;
      end else begin
        s1_v[p]     <= ld_v[p];
        s1_serve[p] <= serve[p];
      end
      s1_tag[p]  <= ld_addr[p][TAG_LO +: TAG_W];
      s1_set[p]  <= ld_addr[p][SET_LO +: SET_W];
      s1_bank[p] <= ld_addr[p][OFF_W +: BANK_W];
    end

    logic m0, m1;
    logic [2*WORD_W-1:0] pair;
    assign m0 = vld_q[p][0] && (tags_q[p][0 +: TAG_W] == s1_tag[p]);
    assign m1 = vld_q[p][1] && (tags_q[p][TAG_W +: TAG_W] == s1_tag[p]);
    assign hit[p]     = s1_serve[p] && (m0 || m1);
    assign hit_way[p] = m1;
    assign pair       = bank_q[s1_bank[p]];
    assign word[p]    = hit_way[p] ? pair[WORD_W +: WORD_W] : pair[0 +: WORD_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        r_valid[p] <= 1'b0;
        r_hit[p]   <= 1'b0;
        r_retry[p] <= 1'b0;
        r_data[p]  <= '0;
      end else begin
        r_valid[p] <= s1_v[p];
        r_hit[p]   <= hit[p];
        r_retry[p] <= s1_v[p] && !s1_serve[p];
        r_data[p]  <= hit[p] ? word[p] : '0;
      end
    end
  end

  // replacement bit per set: later assignments win (port 0 over port 1, fill over both)
  always_ff @(posedge clk) begin
    if (rst) begin
      repl <= '0;
    end else begin
      if (hit[1]) repl[s1_set[1]] <= ~hit_way[1];
      if (hit[0]) repl[s1_set[0]] <= ~hit_way[0];
      if (fill_valid) repl[fill_set] <= ~victim;
    end
  end

  assign rsp0_valid = r_valid[0];
  assign rsp0_hit   = r_hit[0];
  assign rsp0_retry = r_retry[0];
  assign rsp0_data  = r_data[0];
  assign rsp1_valid = r_valid[1];
  assign rsp1_hit   = r_hit[1];
  assign rsp1_retry = r_retry[1];
  assign rsp1_data  = r_data[1];
endmodule

// File: rtl/dcache_dual_load_chk.sv
module dcache_dual_load_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 3,
  parameter int BANK_W = 3,
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              ld0_valid,
  input logic [ADDR_W-1:0] ld0_addr,
  input logic              ld1_valid,
  input logic [ADDR_W-1:0] ld1_addr,
  input logic              fill_valid,
  input logic              rsp0_valid,
  input logic              rsp0_hit,
  input logic              rsp0_retry,
  input logic [WORD_W-1:0] rsp0_data,
  input logic              rsp1_valid,
  input logic              rsp1_hit,
  input logic              rsp1_retry,
  input logic [WORD_W-1:0] rsp1_data
);
  logic both, same_bank, same_word;
  assign both      = ld0_valid && ld1_valid && !fill_valid;
  assign same_bank = ld0_addr[OFF_W +: BANK_W] == ld1_addr[OFF_W +: BANK_W];
  assign same_word = ld0_addr[ADDR_W-1:OFF_W] == ld1_addr[ADDR_W-1:OFF_W];

  p_resp_due_r2: assert property (@(posedge clk) disable iff (rst)
    ld0_valid |-> ##2 rsp0_valid);
  p_no_resp_r2: assert property (@(posedge clk) disable iff (rst)
    !ld1_valid |-> ##2 !rsp1_valid);
  p_retry_clean_r4: assert property (@(posedge clk) disable iff (rst)
    rsp1_retry |-> (!rsp1_hit && rsp1_data == '0));
  p_split_banks_r5: assert property (@(posedge clk) disable iff (rst)
    both && !same_bank |-> ##2 (!rsp0_retry && !rsp1_retry));
  p_port0_first_r6: assert property (@(posedge clk) disable iff (rst)
    both && same_bank && !same_word |-> ##2 (!rsp0_retry && rsp1_retry));
  p_shared_word_r7: assert property (@(posedge clk) disable iff (rst)
    both && same_word |-> ##2 (rsp0_hit == rsp1_hit && rsp0_data == rsp1_data && !rsp1_retry));
  p_fill_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    fill_valid && ld0_valid |-> ##2 rsp0_retry);
  p_fill_blocks1_r8: assert property (@(posedge clk) disable iff (rst)
    fill_valid && ld1_valid |-> ##2 rsp1_retry);
endmodule

bind dcache_dual_load dcache_dual_load_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst(rst),
  .ld0_valid(ld0_valid), .ld0_addr(ld0_addr), .ld1_valid(ld1_valid), .ld1_addr(ld1_addr),
  .fill_valid(fill_valid),
  .rsp0_valid(rsp0_valid), .rsp0_hit(rsp0_hit), .rsp0_retry(rsp0_retry), .rsp0_data(rsp0_data),
  .rsp1_valid(rsp1_valid), .rsp1_hit(rsp1_hit), .rsp1_retry(rsp1_retry), .rsp1_data(rsp1_data)
);

// File: tb/tb_dcache_dual_load.sv
module tb_dcache_dual_load;
  localparam int SETS = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic ld0_valid = 0, ld1_valid = 0, fill_valid = 0;
  logic [31:0] ld0_addr = 0, ld1_addr = 0, fill_addr = 0;
  logic [511:0] fill_line = 0;
  logic rsp0_valid, rsp0_hit, rsp0_retry, rsp1_valid, rsp1_hit, rsp1_retry;
  logic [63:0] rsp0_data, rsp1_data;

  dcache_dual_load dut (
    .clk(clk), .rst(rst),
    .ld0_valid(ld0_valid), .ld0_addr(ld0_addr), .ld1_valid(ld1_valid), .ld1_addr(ld1_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_line(fill_line),
    .rsp0_valid(rsp0_valid), .rsp0_hit(rsp0_hit), .rsp0_retry(rsp0_retry), .rsp0_data(rsp0_data),
    .rsp1_valid(rsp1_valid), .rsp1_hit(rsp1_hit), .rsp1_retry(rsp1_retry), .rsp1_data(rsp1_data)
  );

  int checks = 0, failures = 0;

  // bench model of the cache state
  logic [16:0]  mtag  [SETS][2];
  logic         mval  [SETS][2];
  logic         mrepl [SETS];
  logic [511:0] mline [SETS][2];

  // expected responses: [stage][port], stage 1 is due at this falling edge
  logic        e_v [2][2], e_h [2][2], e_r [2][2];
  logic [63:0] e_d [2][2];
  string       e_l [2][2];
  string       hint = "";

  function automatic logic [31:0] mk(int tag, int set, int bank, int byt);
    return {tag[16:0], set[8:0], bank[2:0], byt[2:0]};
  endfunction

  function automatic logic [511:0] line_of(logic [31:0] a);
    logic [511:0] l;
    for (int k = 0; k < 8; k++) l[k*64 +: 64] = {6'd0, a[31:6], 24'hC0FFEE, 5'd0, 3'(k)};
    return l;
  endfunction

  task automatic lookup(input logic [31:0] a, output logic h, output logic w);
    h = 0; w = 0;
    for (int i = 0; i < 2; i++)
      if (mval[a[14:6]][i] && mtag[a[14:6]][i] == a[31:15]) begin h = 1; w = 1'(i); end
  endtask

  task automatic check_due();
    logic av [2], ah [2], ar [2];
    logic [63:0] ad [2];
    av[0] = rsp0_valid; ah[0] = rsp0_hit; ar[0] = rsp0_retry; ad[0] = rsp0_data;
    av[1] = rsp1_valid; ah[1] = rsp1_hit; ar[1] = rsp1_retry; ad[1] = rsp1_data;
    for (int p = 0; p < 2; p++) begin
      checks++;
      if (av[p] !== e_v[1][p] || ah[p] !== e_h[1][p] || ar[p] !== e_r[1][p] || ad[p] !== e_d[1][p]) begin
        failures++;
        $display("FAIL %s port%0d: got v=%b h=%b r=%b d=%h, expected v=%b h=%b r=%b d=%h",
                 e_l[1][p], p, av[p], ah[p], ar[p], ad[p], e_v[1][p], e_h[1][p], e_r[1][p], e_d[1][p]);
      end
    end
  endtask

  task automatic step(input logic v0, input logic [31:0] a0, input logic v1, input logic [31:0] a1,
                      input logic fv, input logic [31:0] fa);
    logic v [2];
    logic [31:0] a [2];
    logic h, w;
    logic hw [2], hh [2];
    @(negedge clk);
    check_due();
    for (int p = 0; p < 2; p++) begin
      e_v[1][p] = e_v[0][p]; e_h[1][p] = e_h[0][p]; e_r[1][p] = e_r[0][p];
      e_d[1][p] = e_d[0][p]; e_l[1][p] = e_l[0][p];
    end
    v[0] = v0; v[1] = v1; a[0] = a0; a[1] = a1;
    for (int p = 0; p < 2; p++) begin
      e_v[0][p] = v[p]; e_h[0][p] = 0; e_r[0][p] = 0; e_d[0][p] = '0; hh[p] = 0; hw[p] = 0;
      if (!v[p]) e_l[0][p] = "R2";
      else if (fv) begin e_r[0][p] = 1; e_l[0][p] = "R8"; end
      else if (p == 1 && v0 && a0[5:3] == a1[5:3] && a0[31:3] != a1[31:3]) begin
        e_r[0][p] = 1; e_l[0][p] = "R6";
      end else begin
        lookup(a[p], h, w);
        hh[p] = h; hw[p] = w;
        if (h) begin
          e_h[0][p] = 1; e_d[0][p] = mline[a[p][14:6]][w][a[p][5:3]*64 +: 64];
          e_l[0][p] = (v0 && v1 && a0[31:3] == a1[31:3]) ? "R7" : (v0 && v1) ? "R5" : "R3";
        end else e_l[0][p] = (v0 && v1 && a0[31:3] == a1[31:3]) ? "R7" : "R4";
      end
      if (hint != "" && v[p]) e_l[0][p] = hint;
    end
    if (hh[1]) mrepl[a1[14:6]] = ~hw[1];
    if (hh[0]) mrepl[a0[14:6]] = ~hw[0];
    if (fv) begin
      logic vic;
      vic = !mval[fa[14:6]][0] ? 1'b0 : !mval[fa[14:6]][1] ? 1'b1 : mrepl[fa[14:6]];
      mtag[fa[14:6]][vic] = fa[31:15]; mval[fa[14:6]][vic] = 1;
      mline[fa[14:6]][vic] = line_of(fa); mrepl[fa[14:6]] = ~vic;
    end
    ld0_valid = v0; ld0_addr = a0; ld1_valid = v1; ld1_addr = a1;
    fill_valid = fv; fill_addr = fa; fill_line = fv ? line_of(fa) : '0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0);
  endtask

  // an idle cycle first lets earlier hits reach the replacement bits (R10)
  task automatic fill(input logic [31:0] fa, input logic v0, input logic [31:0] a0,
                      input logic v1, input logic [31:0] a1);
    logic h, w;
    lookup(fa, h, w);
    if (h) return;
    idle();
    step(v0, a0, v1, a1, 1, fa);
  endtask

  task automatic drain();
    idle(); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not end, got timeout, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 2; w++) begin mval[s][w] = 0; mtag[s][w] = 0; mline[s][w] = 0; mrepl[s] = 0; end
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 2; p++) begin
        e_v[s][p] = 0; e_h[s][p] = 0; e_r[s][p] = 0; e_d[s][p] = 0; e_l[s][p] = "R1";
      end
    repeat (4) @(posedge clk);
    // R1: no valid response while reset is held
    @(negedge clk);
    checks++;
    if (rsp0_valid !== 1'b0 || rsp1_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1: got v0=%b v1=%b, expected 0 0", rsp0_valid, rsp1_valid);
    end
    rst = 1'b0;

    // R8: fill with both ports loading; R3 and R5 sweep all banks afterwards
    fill(mk(1, 5, 0, 0), 1, mk(1, 5, 2, 0), 1, mk(1, 5, 3, 0));
    for (int k = 0; k < 8; k++) step(1, mk(1, 5, k, 0), 1, mk(1, 5, (k + 1) % 8, 4), 0, 0);
    // R6: same bank, different words (port 1 reads an unfilled set)
    step(1, mk(1, 5, 4, 0), 1, mk(1, 6, 4, 0), 0, 0);
    // R7: identical word, with and without a hit
    step(1, mk(1, 5, 6, 1), 1, mk(1, 5, 6, 5), 0, 0);
    step(1, mk(7, 9, 2, 0), 1, mk(7, 9, 2, 0), 0, 0);
    // R4: single miss
    step(1, mk(3, 77, 1, 0), 0, 0, 0, 0);
    // R9: second line into an invalid way 1
    hint = "R9";
    fill(mk(2, 5, 0, 0), 0, 0, 0, 0);
    step(1, mk(2, 5, 7, 0), 1, mk(1, 5, 0, 0), 0, 0);
    // R10: port 0 hits way 0 and port 1 hits way 1 of one set; port 0's update is kept
    hint = "R10";
    step(1, mk(1, 5, 1, 0), 1, mk(2, 5, 2, 0), 0, 0);
    fill(mk(3, 5, 0, 0), 0, 0, 0, 0);
    step(1, mk(2, 5, 3, 0), 1, mk(1, 5, 4, 0), 0, 0);
    step(1, mk(3, 5, 5, 0), 0, 0, 0, 0);
    // R9: with both ways valid the replacement bit picks way 0 now
    hint = "R9";
    fill(mk(2, 5, 0, 0), 0, 0, 0, 0);
    step(1, mk(1, 5, 0, 0), 1, mk(3, 5, 1, 0), 0, 0);
    step(1, mk(2, 5, 2, 0), 0, 0, 0, 0);
    hint = "";
    drain();

    // constrained random mix over a small address pool
    for (int i = 0; i < 3000; i++) begin
      int tg [2], st [2], bk [2];
      logic v [2];
      logic [31:0] a [2];
      for (int p = 0; p < 2; p++) begin
        tg[p] = $urandom_range(0, 3);
        case ($urandom_range(0, 3))
          0: st[p] = 0;
          1: st[p] = 5;
          2: st[p] = 300;
          default: st[p] = SETS - 1;
        endcase
        bk[p] = $urandom_range(0, 7);
        v[p]  = ($urandom_range(0, 9) < 8);
        a[p]  = mk(tg[p], st[p], bk[p], $urandom_range(0, 7));
      end
      case ($urandom_range(0, 4))
        0: a[1] = a[0];
        1: a[1] = mk(tg[1], st[1], bk[0], 0);
        default: ;
      endcase
      if ($urandom_range(0, 9) == 0) fill(mk(tg[0], st[0], 0, 0), v[0], a[0], v[1], a[1]);
      else step(v[0], a[0], v[1], a[1], 0, 0);
    end
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule